// File: doc/BRIEF.md
# Link-Access-Procedure Receive Deframer

This block sits after the line interface on the receive side of a packet-over-TDM link that uses LAPS framing. It takes one octet per cycle. It finds frames bounded by `7E` flag octets, undoes octet transparency, drops rate-adaptation fill and detects abort sequences. The four header octets (address, control and a two-octet service access point) are compared against configured values. A 32-bit frame check sequence is verified over the frame, and the frame length is checked against configured limits.

Payload octets leave the block with the header and check sequence removed. Start and end markers travel with the payload, and an error bit is carried on the end marker. The block cannot withdraw octets it has already sent, so a bad frame is reported through that error bit on its last octet. Two saturating counters record frames with a failed check sequence and frames cut short by an abort. Downstream logic uses the markers to accept or discard each packet.

Top module: `laps_rx_deframer`

## Requirements
- R1: After reset all outputs and both counters are zero, and every octet is ignored until the first `7E` is seen.
- R2: A received `7D 5E` yields the data octet `7E`, and `7D 5D` yields `7D`.
- R3: A received `7D DD` pair is removed and yields no octet at all.
- R4: Decoded octets 0 to 3 of a frame are header and the last 4 are the check sequence; neither is output. `out_sof` marks the first payload octet and `out_eof` the last. A payload octet appears 2 cycles after the fifth decoded octet that follows it arrives, or 2 cycles after the closing flag arrives.
- R5: The frame is flagged bad when octet 0 differs from `cfg_addr`, octet 1 from `cfg_ctrl`, octet 2 from `cfg_sapi[15:8]` or octet 3 from `cfg_sapi[7:0]`. A bad frame has `out_err` set together with its `out_eof`.
- R6: The check sequence is CRC-32: reflected polynomial 0x04C11DB7, register preset to all ones, result complemented and sent least significant octet first. On a mismatch the frame is flagged bad and `fcs_err_cnt` increments in the cycle its end marker appears.
- R7: A frame whose decoded length n, counted from the header through the check sequence, is above `cfg_max_len` or below `cfg_min_len` is flagged bad. No counter changes because of the length.
- R8: `7D` followed by `7E` aborts the frame and increments `abort_cnt`. If payload output has begun, the held octet is sent with `out_eof` and `out_err`. The `7E` opens the next frame.
- R9: `7D` followed by any octet other than `5E`, `5D`, `DD` or `7E` discards that octet and flags the frame bad.
- R10: Adjacent flags and frames of 1 to 8 decoded octets produce no output and change no counter.
- R11: Both counters are CNT_W bits wide (16 by default) and saturate at all ones. `cnt_clear` zeroes both at the next edge and takes priority over an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | `in_byte` carries a line octet this cycle |
| in_byte | input | 8 | Received line octet |
| cfg_addr | input | 8 | Expected address octet |
| cfg_ctrl | input | 8 | Expected control octet |
| cfg_sapi | input | 16 | Expected service access point, high octet first on the line |
| cfg_min_len | input | LEN_W | Smallest legal decoded frame length |
| cfg_max_len | input | LEN_W | Largest legal decoded frame length |
| cnt_clear | input | 1 | Zero both counters |
| out_valid | output | 1 | A payload octet is present |
| out_data | output | 8 | Payload octet |
| out_sof | output | 1 | First payload octet of a frame |
| out_eof | output | 1 | Last payload octet of a frame |
| out_err | output | 1 | Frame is bad; only set with `out_eof` |
| fcs_err_cnt | output | CNT_W | Frames with a failed check sequence |
| abort_cnt | output | CNT_W | Aborted frames |

## Verification
A line octet passes through two registers, the escape decoder and the frame stage, so any result it causes becomes visible 2 cycles after it is driven. A payload octet is held back by five decoded octets, which lets the end marker land on the last payload octet. The counters change in the same cycle as the end marker, while `cnt_clear` acts at the very next edge. The bench feeds each line octet to a behavioural model that keeps the frame in a queue. It pushes the result into a two-deep expectation pipe and compares every output away from the clock edge. Counter expectations are combined with the clear at the point where the clear is driven.

// File: rtl/laps_rx_pkg.sv
// Package: octet codes, event type and CRC-32 step shared by the receive deframer.
package laps_rx_pkg;

    localparam logic [7:0] FLAG_OCT  = 8'h7E;
    localparam logic [7:0] ESC_OCT   = 8'h7D;
    localparam logic [7:0] ESC_FLAG  = 8'h5E;
    localparam logic [7:0] ESC_ESC   = 8'h5D;
    localparam logic [7:0] RATE_FILL = 8'hDD;

    localparam int HDR_OCTS = 4;
    localparam int FCS_OCTS = 4;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_OCTET,
        EV_FLAG,
        EV_ABORT,
        EV_BADESC
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e   kind;
        logic [7:0] data;
    } rx_ev_t;

    // One octet of a reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] d);
        logic [31:0] c;
        c = crc ^ {24'h0, d};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/laps_rx_unescape.sv
// Escape decoder: turns the line octet stream into one registered event per cycle.
// Flag gives EV_FLAG, escape+flag gives EV_ABORT, escape pairs give EV_OCTET or nothing,
// and an unknown escape gives EV_BADESC. Assumes at most one octet per cycle.
module laps_rx_unescape
    import laps_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output rx_ev_t     ev
);

    logic   esc_pend;
    logic   esc_pend_nxt;
    rx_ev_t ev_nxt;

    // Classify the incoming octet against the pending-escape state.
    always_comb begin
        ev_nxt       = '{kind: EV_NONE, data: in_byte};
        esc_pend_nxt = esc_pend;
        if (in_valid) begin
            if (in_byte == FLAG_OCT) begin
                ev_nxt.kind  = esc_pend ? EV_ABORT : EV_FLAG;
                esc_pend_nxt = 1'b0;
            end else if (esc_pend) begin
                esc_pend_nxt = 1'b0;
                case (in_byte)
                    ESC_FLAG:  ev_nxt = '{kind: EV_OCTET, data: FLAG_OCT};
                    ESC_ESC:   ev_nxt = '{kind: EV_OCTET, data: ESC_OCT};
                    RATE_FILL: ev_nxt.kind = EV_NONE;
                    default:   ev_nxt.kind = EV_BADESC;
                endcase
            end else if (in_byte == ESC_OCT) begin
                esc_pend_nxt = 1'b1;
            end else begin
                ev_nxt.kind = EV_OCTET;
            end
        end
    end

    // Register the event and the escape state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev       <= '{kind: EV_NONE, data: 8'h00};
            esc_pend <= 1'b0;
        end else begin
            ev       <= ev_nxt;
            esc_pend <= esc_pend_nxt;
        end
    end

    // R2: a flag octet on the line never becomes a data octet.
    p_flag_not_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_byte == FLAG_OCT) |=> (ev.kind == EV_FLAG || ev.kind == EV_ABORT));

    // R3: an opening escape octet produces no event by itself.
    p_esc_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_byte == ESC_OCT && !esc_pend) |=> (ev.kind == EV_NONE));

endmodule

// File: rtl/laps_rx_crc32.sv
// CRC-32 accumulator over decoded frame octets. It is preset on clr and updated on en.
// ok is high when the register holds the residue a correct frame leaves after its check sequence.
module laps_rx_crc32
    import laps_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] data,
    output logic       ok
);

    logic [31:0] crc_q;

    // Preset on frame boundary, otherwise fold in each octet.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= '1;
        end else if (en) begin
            crc_q <= crc32_step(crc_q, data);
        end
    end

    assign ok = (crc_q == CRC_RESIDUE);

endmodule

// File: rtl/laps_rx_sat_counter.sv
// Saturating event counter with a synchronous clear that wins over an increment.
module laps_rx_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] CMAX = {W{1'b1}};

    // Clear, else count up until all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc && count != CMAX) begin
            count <= count + 1'b1;
        end
    end

    // R11: a full counter stays full unless cleared.
    p_sat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && count == CMAX) |=> (count == CMAX));

    // R11: clear empties the counter at the next edge.
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/laps_rx_deframer.sv
// Receive deframer top. It tracks frame state on the decoded event stream and holds
// FCS_OCTS+1 octets back so the end marker lands on the last payload octet. It checks the
// header, CRC and length, and drives the payload outputs and both error counters.
// Assumes cfg_* are stable while frames are received.
module laps_rx_deframer
    import laps_rx_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic [7:0]       cfg_addr,
    input  logic [7:0]       cfg_ctrl,
    input  logic [15:0]      cfg_sapi,
    input  logic [LEN_W-1:0] cfg_min_len,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic             cnt_clear,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic             out_err,
    output logic [CNT_W-1:0] fcs_err_cnt,
    output logic [CNT_W-1:0] abort_cnt
);

    localparam int HOLD_DEPTH    = FCS_OCTS + 1;
    localparam int MIN_OUT_OCTS  = HDR_OCTS + FCS_OCTS + 1;
    localparam int HDR_IDX_W     = $clog2(HDR_OCTS);
    localparam logic [LEN_W-1:0] LEN_MAX   = {LEN_W{1'b1}};
    localparam logic [LEN_W-1:0] LEN_READY = LEN_W'(MIN_OUT_OCTS);
    localparam logic [LEN_W-1:0] LEN_HDR   = LEN_W'(HDR_OCTS);

    rx_ev_t           ev;
    logic             hunting;
    logic [LEN_W-1:0] oct_cnt;
    logic [7:0]       hold [HOLD_DEPTH];
    logic             hdr_bad;
    logic             esc_bad;
    logic             crc_ok;
    logic [HDR_OCTS-1:0][7:0] hdr_exp;

    logic is_octet, is_close, is_abort, is_badesc, start_hunt, restart;
    logic frame_ready, len_bad, hdr_mis;
    logic emit, emit_sof, emit_eof, emit_err;
    logic fcs_inc, abort_inc;

    laps_rx_unescape u_unescape (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .ev       (ev)
    );

    laps_rx_crc32 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .en    (is_octet),
        .data  (ev.data),
        .ok    (crc_ok)
    );

    // Expected header octets in line order: address, control, SAPI high, SAPI low.
    assign hdr_exp = {cfg_sapi[7:0], cfg_sapi[15:8], cfg_ctrl, cfg_addr};

    // Decode the current event against frame state.
    always_comb begin
        is_octet    = !hunting && ev.kind == EV_OCTET;
        is_close    = !hunting && ev.kind == EV_FLAG;
        is_abort    = !hunting && ev.kind == EV_ABORT;
        is_badesc   = !hunting && ev.kind == EV_BADESC;
        start_hunt  = hunting && (ev.kind == EV_FLAG || ev.kind == EV_ABORT);
        restart     = is_close || is_abort || start_hunt;
        frame_ready = oct_cnt >= LEN_READY;
        len_bad     = (oct_cnt > cfg_max_len) || (oct_cnt < cfg_min_len);
        hdr_mis     = is_octet && (oct_cnt < LEN_HDR) &&
                      (ev.data != hdr_exp[oct_cnt[HDR_IDX_W-1:0]]);
    end

    // Decide what leaves the block this cycle.
    always_comb begin
        emit      = frame_ready && (is_octet || is_close || is_abort);
        emit_sof  = oct_cnt == LEN_READY;
        emit_eof  = is_close || is_abort;
        emit_err  = is_abort || (is_close && (hdr_bad || esc_bad || !crc_ok || len_bad));
        fcs_inc   = is_close && frame_ready && !crc_ok;
        abort_inc = is_abort;
    end

    // Frame state: hunt, octet count and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hunting <= 1'b1;
            oct_cnt <= '0;
            hdr_bad <= 1'b0;
            esc_bad <= 1'b0;
        end else if (restart) begin
            hunting <= 1'b0;
            oct_cnt <= '0;
            hdr_bad <= 1'b0;
            esc_bad <= 1'b0;
        end else begin
            if (is_octet && oct_cnt != LEN_MAX) begin
                oct_cnt <= oct_cnt + 1'b1;
            end
            if (hdr_mis) begin
                hdr_bad <= 1'b1;
            end
            if (is_badesc) begin
                esc_bad <= 1'b1;
            end
        end
    end

    // Hold-back line: the newest octet enters stage 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold[0] <= '0;
        end else if (is_octet) begin
            hold[0] <= ev.data;
        end
    end

    for (genvar g = 1; g < HOLD_DEPTH; g++) begin : g_hold
        // Shift each older stage along on every decoded octet.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold[g] <= '0;
            end else if (is_octet) begin
                hold[g] <= hold[g-1];
            end
        end
    end

    // Output register for the payload stream and markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= emit;
            out_data  <= emit ? hold[HOLD_DEPTH-1] : 8'h00;
            out_sof   <= emit && emit_sof;
            out_eof   <= emit && emit_eof;
            out_err   <= emit && emit_eof && emit_err;
        end
    end

    laps_rx_sat_counter #(.W(CNT_W)) u_fcs_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clear),
        .inc   (fcs_inc),
        .count (fcs_err_cnt)
    );

    laps_rx_sat_counter #(.W(CNT_W)) u_abort_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clear),
        .inc   (abort_inc),
        .count (abort_cnt)
    );

    // R4: markers only ride on a valid octet.
    p_marks_need_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eof) |-> out_valid);

    // R5: the error bit only appears on an end marker.
    p_err_only_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_eof);

    // R1: while hunting, nothing is sent.
    p_hunt_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hunting |=> !out_valid);

    // R10: closing a short frame sends nothing.
    p_short_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_close && !frame_ready) |=> !out_valid);

    // R8: an abort advances the abort counter by one unless full or cleared.
    p_abort_counted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_abort && !cnt_clear && abort_cnt != {CNT_W{1'b1}})
        |=> (abort_cnt == $past(abort_cnt) + 1'b1));

endmodule

// File: tb/laps_rx_deframer_tb.sv
// Bench: behavioural queue model, expectations piped two cycles, compared every cycle.
module laps_rx_deframer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 12;
    localparam int CNT_W = 3;
    localparam int CMAX  = (1 << CNT_W) - 1;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       sof;
        logic       eof;
        logic       err;
        logic       inc_fcs;
        logic       inc_abort;
        logic [CNT_W-1:0] fcs;
        logic [CNT_W-1:0] abt;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [7:0] cfg_addr = 8'h04;
    logic [7:0] cfg_ctrl = 8'h03;
    logic [15:0] cfg_sapi = 16'hFE01;
    logic [LEN_W-1:0] cfg_min_len = 12'd9;
    logic [LEN_W-1:0] cfg_max_len = 12'd60;
    logic cnt_clear = 1'b0;
    logic out_valid, out_sof, out_eof, out_err;
    logic [7:0] out_data;
    logic [CNT_W-1:0] fcs_err_cnt, abort_cnt;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string cur_req = "R1";

    exp_t exp_a, exp_b;
    int   m_fcs, m_abt;
    bit   m_hunt, m_esc, m_badesc;
    logic [7:0] m_q[$];
    logic [7:0] pl[$];
    bit   clr_req = 0;

    laps_rx_deframer #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .cfg_addr(cfg_addr), .cfg_ctrl(cfg_ctrl), .cfg_sapi(cfg_sapi),
        .cfg_min_len(cfg_min_len), .cfg_max_len(cfg_max_len), .cnt_clear(cnt_clear),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_err(out_err),
        .fcs_err_cnt(fcs_err_cnt), .abort_cnt(abort_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ref_crc(input logic [7:0] q[$], input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, q[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, expv, $time);
        end
    endtask

    task automatic m_reset_frame();
        m_q.delete();
        m_badesc = 0;
    endtask

    // Model: append one decoded octet, emitting the one five places back.
    task automatic m_push(input logic [7:0] x, inout exp_t e);
        int j;
        if (m_hunt) return;
        j = m_q.size();
        if (j >= 9) begin
            e.valid = 1; e.data = m_q[j-5]; e.sof = (j == 9);
        end
        m_q.push_back(x);
    endtask

    // Model: react to one line octet; result is due two cycles later.
    task automatic m_step(input logic v, input logic [7:0] b, output exp_t e);
        int n;
        logic [31:0] fcs_rx;
        bit bad;
        e = '0;
        if (!v) return;
        if (b == 8'h7E) begin
            n = m_q.size();
            if (m_hunt) begin
                m_hunt = 0; m_reset_frame();
            end else if (m_esc) begin
                e.inc_abort = 1;
                if (n >= 9) begin
                    e.valid = 1; e.data = m_q[n-5]; e.sof = (n == 9); e.eof = 1; e.err = 1;
                end
                m_reset_frame();
            end else if (n > 0 && n < 9) begin
                m_reset_frame();
            end else if (n >= 9) begin
                fcs_rx = {m_q[n-1], m_q[n-2], m_q[n-3], m_q[n-4]};
                bad = m_badesc;
                if (m_q[0] != cfg_addr || m_q[1] != cfg_ctrl ||
                    m_q[2] != cfg_sapi[15:8] || m_q[3] != cfg_sapi[7:0]) bad = 1;
                if (n > int'(cfg_max_len) || n < int'(cfg_min_len)) bad = 1;
                if (fcs_rx != ref_crc(m_q, n - 4)) begin bad = 1; e.inc_fcs = 1; end
                e.valid = 1; e.data = m_q[n-5]; e.sof = (n == 9); e.eof = 1; e.err = bad;
                m_reset_frame();
            end
            m_esc = 0;
            return;
        end
        if (m_esc) begin
            m_esc = 0;
            if (b == 8'h5E) m_push(8'h7E, e);
            else if (b == 8'h5D) m_push(8'h7D, e);
            else if (b != 8'hDD && !m_hunt) m_badesc = 1;
        end else if (b == 8'h7D) begin
            m_esc = 1;
        end else begin
            m_push(b, e);
        end
    endtask

    // One clock: check outputs, advance expectations, drive the next octet.
    task automatic cycle(input logic v, input logic [7:0] b);
        exp_t nb;
        @(negedge clk);
        chk("out_valid", out_valid, exp_a.valid);
        if (exp_a.valid) begin
            chk("out_data", out_data, exp_a.data);
            chk("out_sof", out_sof, exp_a.sof);
            chk("out_eof", out_eof, exp_a.eof);
            chk("out_err", out_err, exp_a.err);
        end
        chk("fcs_err_cnt", fcs_err_cnt, exp_a.fcs);
        chk("abort_cnt", abort_cnt, exp_a.abt);
        if (clr_req) begin
            m_fcs = 0; m_abt = 0;
        end else begin
            if (exp_b.inc_fcs && m_fcs < CMAX) m_fcs++;
            if (exp_b.inc_abort && m_abt < CMAX) m_abt++;
        end
        exp_a = exp_b;
        exp_a.fcs = CNT_W'(m_fcs);
        exp_a.abt = CNT_W'(m_abt);
        cnt_clear = clr_req;
        in_valid = v;
        in_byte = b;
        m_step(v, b, nb);
        exp_b = nb;
    endtask

    task automatic send_octet(input logic [7:0] x);
        if (x == 8'h7E) begin cycle(1, 8'h7D); cycle(1, 8'h5E); end
        else if (x == 8'h7D) begin cycle(1, 8'h7D); cycle(1, 8'h5D); end
        else cycle(1, x);
    endtask

    // Frame from pl: header (one octet optionally corrupted), payload, FCS, closing flag.
    task automatic tx_frame(input bit bad_fcs, input int hdr_bad_idx, input bit fill);
        logic [7:0] f[$];
        logic [31:0] c;
        f.push_back(cfg_addr); f.push_back(cfg_ctrl);
        f.push_back(cfg_sapi[15:8]); f.push_back(cfg_sapi[7:0]);
        if (hdr_bad_idx >= 0) f[hdr_bad_idx] = f[hdr_bad_idx] ^ 8'h10;
        foreach (pl[i]) f.push_back(pl[i]);
        c = ref_crc(f, f.size());
        if (bad_fcs) c = c ^ 32'h0000_0100;
        for (int i = 0; i < 4; i++) f.push_back(c[8*i +: 8]);
        foreach (f[i]) begin
            send_octet(f[i]);
            if (fill && (i % 3 == 1)) begin cycle(1, 8'h7D); cycle(1, 8'hDD); end
        end
        cycle(1, 8'h7E);
    endtask

    task automatic make_pl(input int len, input logic [7:0] seed);
        pl.delete();
        for (int i = 0; i < len; i++) pl.push_back(seed + 8'(i * 29));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 8'h00);
    endtask

    initial begin
        exp_a = '0; exp_b = '0;
        m_fcs = 0; m_abt = 0; m_hunt = 1; m_esc = 0; m_badesc = 0;
        repeat (4) @(negedge clk);
        cur_req = "R1";
        chk("reset out_valid", out_valid, 0);
        chk("reset out_eof", out_eof, 0);
        chk("reset fcs_err_cnt", fcs_err_cnt, 0);
        chk("reset abort_cnt", abort_cnt, 0);
        rst_n = 1'b1;

        // R1: junk before the first flag, including a full-looking frame body, is ignored.
        make_pl(6, 8'h31);
        foreach (pl[i]) cycle(1, pl[i]);
        for (int i = 0; i < 10; i++) cycle(1, 8'h55);
        cycle(1, 8'h7E);
        idle(3);

        // R4: good frames, longer and minimal payload.
        cur_req = "R4";
        make_pl(7, 8'h10); tx_frame(0, -1, 0);
        make_pl(1, 8'hA0); tx_frame(0, -1, 0);
        idle(4);

        // R2: escaped flag and escape octets in payload.
        cur_req = "R2";
        pl.delete();
        pl.push_back(8'h7E); pl.push_back(8'h11); pl.push_back(8'h7D);
        pl.push_back(8'h7E); pl.push_back(8'h7D); pl.push_back(8'h22);
        tx_frame(0, -1, 0);
        idle(3);

        // R3: rate-adaptation pairs sprinkled through the frame.
        cur_req = "R3";
        make_pl(8, 8'h44); tx_frame(0, -1, 1);
        idle(3);

        // R5: wrong address, wrong SAPI low octet.
        cur_req = "R5";
        make_pl(5, 8'h01); tx_frame(0, 0, 0);
        make_pl(5, 8'h02); tx_frame(0, 3, 0);
        idle(3);

        // R6: corrupted check sequence, counter steps.
        cur_req = "R6";
        make_pl(6, 8'h66); tx_frame(1, -1, 0);
        make_pl(3, 8'h67); tx_frame(1, -1, 0);
        idle(3);

        // R7: too long, then too short, with tighter limits.
        cur_req = "R7";
        cfg_max_len = 12'd20; cfg_min_len = 12'd14;
        make_pl(16, 8'h70); tx_frame(0, -1, 0);
        make_pl(2, 8'h71); tx_frame(0, -1, 0);
        make_pl(10, 8'h72); tx_frame(0, -1, 0);
        cfg_max_len = 12'd60; cfg_min_len = 12'd9;
        idle(3);

        // R8: abort after payload started, then abort early in a frame.
        cur_req = "R8";
        for (int i = 0; i < 12; i++) cycle(1, 8'h20 + 8'(i));
        cycle(1, 8'h7D); cycle(1, 8'h7E);
        cycle(1, 8'h04); cycle(1, 8'h03);
        cycle(1, 8'h7D); cycle(1, 8'h7E);
        make_pl(4, 8'h88); tx_frame(0, -1, 0);
        idle(3);

        // R9: invalid escape inside an otherwise good frame.
        cur_req = "R9";
        cycle(1, 8'h04); cycle(1, 8'h03); cycle(1, 8'hFE); cycle(1, 8'h01);
        cycle(1, 8'h7D); cycle(1, 8'h41);
        make_pl(1, 8'h00);
        cycle(1, 8'h99); cycle(1, 8'h98); cycle(1, 8'h97);
        for (int i = 0; i < 4; i++) cycle(1, 8'h50 + 8'(i));
        cycle(1, 8'h7E);
        idle(3);

        // R10: back-to-back flags and short frames.
        cur_req = "R10";
        cycle(1, 8'h7E); cycle(1, 8'h7E); cycle(1, 8'h7E);
        cycle(1, 8'h04); cycle(1, 8'h03); cycle(1, 8'h12); cycle(1, 8'h7E);
        for (int i = 0; i < 8; i++) cycle(1, 8'h60 + 8'(i));
        cycle(1, 8'h7E);
        idle(3);

        // R11: saturate abort counter, clear, clear racing an increment.
        cur_req = "R11";
        for (int i = 0; i < CMAX + 3; i++) begin cycle(1, 8'h7D); cycle(1, 8'h7E); end
        idle(3);
        clr_req = 1; cycle(0, 8'h00); clr_req = 0;
        idle(2);
        cycle(1, 8'h7D); cycle(1, 8'h7E);
        clr_req = 1; cycle(0, 8'h00); clr_req = 0;
        idle(3);
        make_pl(2, 8'h33); tx_frame(1, -1, 0);
        idle(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule